// File: doc/BRIEF.md
# Dual 8-bit PWM Channel Pair with Buffered Compare Values

This block holds two pulse-width modulation channels. Each has its own 8-bit counter, period and duty value. A single control bit can join the two into one 16-bit channel. Software reaches every setting through a small register port with an address, write data, a write strobe and combinational read data. A shared one-cycle tick input sets the counting rate. Each channel has three bits of its own: enable, output polarity and alignment mode (edge or center).

Period and duty writes land in buffer registers. While a channel runs, the counter compares against a separate set of active copies. The buffers are copied into the active copies only at a counter rollover, while the channel is disabled, or when software writes the channel's counter, which also restarts it. The channel therefore always produces either a whole old cycle or a whole new one. When a channel is disabled, its pin carries a general-purpose data bit instead of the waveform.

Register map (3-bit address). 0 is control: bit0/bit1 enable channel 0/1, bit2/bit3 polarity 0/1, bit4/bit5 center mode 0/1, bit6 join. 1 holds the port data, bit0 for pin 0 and bit1 for pin 1. 2 and 3 are period 0/1, 4 and 5 are duty 0/1, 6 and 7 are counter 0/1. When the channels are joined, the pair forms one 16-bit channel on pin 1. Its high byte is the channel-0 register and its low byte the channel-1 register, and it uses the channel-1 control bits.

Top module: `pwm_pair`

## Requirements
- R1: After reset every control bit is 0, both counters read 0 and each pin equals its port data bit, which resets to 0.
- R2: In edge mode an enabled counter advances once per tick from 0 up to period-1, wraps to 0, and its value reads back at address 6 or 7.
- R3: With polarity 0 the pin is low while count < duty and high once count >= duty. Polarity 1 gives the inverse level.
- R4: A period or duty write to an enabled channel changes nothing until the counter next wraps to 0.
- R5: A period or duty write to a disabled channel is in force from the moment the channel is enabled.
- R6: A write of any value to a counter address clears that counter and makes the buffered period and duty active at once.
- R7: In center mode the counter rises from 0 to the period value, falls back to 0, and repeats. The pin uses the same compare rule as R3.
- R8: Duty 0 with period nonzero gives 100 % (polarity 0 pin constantly high). Duty >= period gives 0 % (constantly low).
- R9: A disabled channel holds its counter at 0, and its pin follows the port data bit.
- R10: With the join bit set, periods {P0,P1}, duties {D0,D1} and one 16-bit counter drive pin 1. Counter address 6 reads the high byte and 7 the low byte, and pin 0 follows port data bit 0.
- R11: A counter does not move in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse shared by all counters |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | CW (8) | Write data |
| rd_data | output | CW (8) | Read data for addr, combinational |
| pwm_pin | output | 2 | Pin outputs, waveform or port data |

## Verification
The counter-bound assertions take for granted that software changes a channel's alignment mode only while that channel is disabled. A mode switch in mid-run can leave the count outside the range the new mode allows. The directed stimulus obeys this: every task disables the channel, then sets the period, duty and mode, and only then enables it. The bench also changes no enable bit in the same cycle as a counter write, so the assertions about held counters are never confounded by two simultaneous causes.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_PORT = 3'd1,
        RA_PER0 = 3'd2,
        RA_PER1 = 3'd3,
        RA_DTY0 = 3'd4,
        RA_DTY1 = 3'd5,
        RA_CNT0 = 3'd6,
        RA_CNT1 = 3'd7
    } reg_addr_e;

    // bit6 join, bits5:4 center, bits3:2 polarity, bits1:0 enable
    typedef struct packed {
        logic       join_ch;
        logic [1:0] center;
        logic [1:0] pol;
        logic [1:0] en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic en;
        logic pol;
        logic center;
    } chan_cfg_t;

    function automatic logic drive_level(input logic past_duty, input logic pol);
        return past_duty ^ pol;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CW-1:0]        wr_data,
    output ctrl_t                ctrl,
    output logic [1:0]           port_bits,
    output logic [1:0][CW-1:0]   per_buf,
    output logic [1:0][CW-1:0]   dty_buf,
    output logic [1:0]           cnt_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            port_bits <= '0;
            per_buf   <= '0;
            dty_buf   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_CTRL: ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
                RA_PORT: port_bits  <= wr_data[1:0];
                RA_PER0: per_buf[0] <= wr_data;
                RA_PER1: per_buf[1] <= wr_data;
                RA_DTY0: dty_buf[0] <= wr_data;
                RA_DTY1: dty_buf[1] <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_wr[0] = wr_en && (reg_addr_e'(addr) == RA_CNT0);
        cnt_wr[1] = wr_en && (reg_addr_e'(addr) == RA_CNT1);
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  chan_cfg_t    cfg,
    input  logic [W-1:0] per_buf,
    input  logic [W-1:0] dty_buf,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         wave
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q, per_q, dty_q, cnt_n;
    logic         up_q, up_n, roll;

    // next-count logic for both alignments
    always_comb begin
        cnt_n = cnt_q;
        up_n  = up_q;
        roll  = 1'b0;
        if (tick) begin
            if (!cfg.center) begin
                if (per_q == ZERO || cnt_q >= per_q - ONE) begin
                    cnt_n = ZERO;
                    roll  = 1'b1;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end else if (up_q) begin
                if (per_q == ZERO) begin
                    cnt_n = ZERO;
                    roll  = 1'b1;
                end else if (cnt_q >= per_q) begin
                    if (cnt_q <= ONE) begin
                        cnt_n = ZERO;
                        roll  = 1'b1;
                    end else begin
                        cnt_n = cnt_q - ONE;
                        up_n  = 1'b0;
                    end
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end else begin
                if (cnt_q <= ONE) begin
                    cnt_n = ZERO;
                    up_n  = 1'b1;
                    roll  = 1'b1;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            up_q  <= 1'b1;
            per_q <= ZERO;
            dty_q <= ZERO;
        end else if (!cfg.en || clr) begin
            cnt_q <= ZERO;
            up_q  <= 1'b1;
            per_q <= per_buf;
            dty_q <= dty_buf;
        end else begin
            cnt_q <= cnt_n;
            up_q  <= up_n;
            if (roll) begin
                per_q <= per_buf;
                dty_q <= dty_buf;
            end
        end
    end

    logic past_duty;
    always_comb begin
        past_duty = (dty_q < per_q) && (cnt_q >= dty_q);
        wave      = drive_level(past_duty, cfg.pol);
        cnt       = cnt_q;
    end

    // R9
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> cnt_q == ZERO);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == ZERO);

    // R11
    no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.en && !tick && !clr |=> $stable(cnt_q));

    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.en && !clr && !roll |=> $stable(per_q) && $stable(dty_q));

    // R2
    edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.en && !cfg.center && per_q != ZERO |-> cnt_q < per_q);

    // R7
    center_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.en && cfg.center |-> cnt_q <= per_q);

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     rd_data,
    output logic [1:0]        pwm_pin
);

    localparam int WW = 2 * CW;

    ctrl_t                ctrl;
    logic [1:0]           port_bits;
    logic [1:0][CW-1:0]   per_buf, dty_buf;
    logic [1:0]           cnt_wr;

    pwm_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .port_bits (port_bits),
        .per_buf   (per_buf),
        .dty_buf   (dty_buf),
        .cnt_wr    (cnt_wr)
    );

    logic [1:0][CW-1:0] cnt_s;
    logic [1:0]         wave_s;
    logic [1:0]         en_s;

    for (genvar i = 0; i < 2; i++) begin : g_split
        chan_cfg_t cfg_s;
        always_comb begin
            en_s[i]      = ctrl.en[i] && !ctrl.join_ch;
            cfg_s.en     = en_s[i];
            cfg_s.pol    = ctrl.pol[i];
            cfg_s.center = ctrl.center[i];
        end
        pwm_core #(.W(CW)) u_core (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cfg     (cfg_s),
            .per_buf (per_buf[i]),
            .dty_buf (dty_buf[i]),
            .clr     (cnt_wr[i]),
            .cnt     (cnt_s[i]),
            .wave    (wave_s[i])
        );
    end

    chan_cfg_t     cfg_w;
    logic [WW-1:0] cnt_w;
    logic          wave_w;

    always_comb begin
        cfg_w.en     = ctrl.en[1] && ctrl.join_ch;
        cfg_w.pol    = ctrl.pol[1];
        cfg_w.center = ctrl.center[1];
    end

    pwm_core #(.W(WW)) u_wide (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cfg     (cfg_w),
        .per_buf ({per_buf[0], per_buf[1]}),
        .dty_buf ({dty_buf[0], dty_buf[1]}),
        .clr     (|cnt_wr),
        .cnt     (cnt_w),
        .wave    (wave_w)
    );

    always_comb begin
        pwm_pin[0] = en_s[0] ? wave_s[0] : port_bits[0];
        if (ctrl.join_ch)
            pwm_pin[1] = cfg_w.en ? wave_w : port_bits[1];
        else
            pwm_pin[1] = en_s[1] ? wave_s[1] : port_bits[1];
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL: rd_data = {{(CW-CTRL_W){1'b0}}, ctrl};
            RA_PORT: rd_data = {{(CW-2){1'b0}}, port_bits};
            RA_PER0: rd_data = per_buf[0];
            RA_PER1: rd_data = per_buf[1];
            RA_DTY0: rd_data = dty_buf[0];
            RA_DTY1: rd_data = dty_buf[1];
            RA_CNT0: rd_data = ctrl.join_ch ? cnt_w[WW-1:CW] : cnt_s[0];
            RA_CNT1: rd_data = ctrl.join_ch ? cnt_w[CW-1:0]  : cnt_s[1];
            default: rd_data = '0;
        endcase
    end

    // R9
    pin0_port_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en[0] |-> pwm_pin[0] == port_bits[0]);

    // R10
    join_pin0_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.join_ch |-> pwm_pin[0] == port_bits[0]);

endmodule

// File: tb/pwm_pair_bench.sv
`timescale 1ns/1ps
module pwm_pair_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_pair #(.CW(8)) u_pwm_pair (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_pin (pwm_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a; #1;
        v = int'(rd_data);
    endtask

    task automatic step(input logic t);
        tick = t;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        rd(3'd6, v); chk("R1 cnt0", v, 0);
        rd(3'd7, v); chk("R1 cnt1", v, 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        chk("R1 pins", int'(pwm_pin), 0);
        wr(3'd1, 8'h03);
        chk("R1 pins follow port", int'(pwm_pin), 3);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_edge();
        int v;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'd5); wr(3'd4, 8'd2);
        wr(3'd0, 8'h01);
        for (int k = 1; k <= 12; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R2 edge count", v, k % 5);
            chk("R3 pol0 level", int'(pwm_pin[0]), ((k % 5) >= 2) ? 1 : 0);
        end
        // count now 2
        for (int k = 0; k < 3; k++) begin
            step(1'b0);
            rd(3'd6, v); chk("R11 no tick hold", v, 2);
        end
        wr(3'd0, 8'h05);
        for (int k = 3; k <= 8; k++) begin
            step(1'b1);
            rd(3'd6, v);
            chk("R3 pol1 level", int'(pwm_pin[0]), (v >= 2) ? 0 : 1);
            chk("R2 edge count pol1", v, k % 5);
        end
        wr(3'd0, 8'h01);
    endtask

    task automatic t_buffer();
        int v;
        wr(3'd6, 8'h00);
        rd(3'd6, v); chk("R6 clear", v, 0);
        wr(3'd2, 8'd3);
        for (int k = 1; k <= 5; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R4 old period until wrap", v, k % 5);
        end
        for (int k = 1; k <= 4; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R4 new period after wrap", v, k % 3);
        end
        wr(3'd2, 8'd8); wr(3'd4, 8'd1);
        wr(3'd6, 8'h55);
        rd(3'd6, v); chk("R6 counter write clears", v, 0);
        chk("R6 pin at zero", int'(pwm_pin[0]), 0);
        for (int k = 1; k <= 7; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R6 new period live", v, k);
            chk("R6 new duty live", int'(pwm_pin[0]), 1);
        end
    endtask

    task automatic t_disabled();
        int v;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'd4); wr(3'd4, 8'd3);
        wr(3'd1, 8'h01);
        for (int k = 0; k < 3; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R9 held at zero", v, 0);
            chk("R9 pin is port bit", int'(pwm_pin[0]), 1);
        end
        wr(3'd1, 8'h00);
        chk("R9 pin is port bit low", int'(pwm_pin[0]), 0);
        wr(3'd0, 8'h01);
        for (int k = 1; k <= 8; k++) begin
            step(1'b1);
            rd(3'd6, v); chk("R5 period from disabled write", v, k % 4);
            chk("R5 duty from disabled write", int'(pwm_pin[0]), ((k % 4) >= 3) ? 1 : 0);
        end
    endtask

    task automatic t_limits();
        int v;
        wr(3'd0, 8'h00); wr(3'd2, 8'd4); wr(3'd4, 8'd0); wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            chk("R8 duty 0 high", int'(pwm_pin[0]), 1);
            step(1'b1);
        end
        wr(3'd0, 8'h00); wr(3'd4, 8'd4); wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            chk("R8 duty eq period low", int'(pwm_pin[0]), 0);
            step(1'b1);
        end
        wr(3'd0, 8'h00); wr(3'd4, 8'd9); wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            chk("R8 duty over period low", int'(pwm_pin[0]), 0);
            step(1'b1);
        end
        rd(3'd6, v); chk("R8 counter still runs", v, 1);
    endtask

    task automatic t_center();
        int v;
        int pos;
        int exp;
        wr(3'd0, 8'h00); wr(3'd2, 8'd3); wr(3'd4, 8'd2);
        wr(3'd0, 8'h11);
        for (int k = 1; k <= 14; k++) begin
            step(1'b1);
            pos = k % 6;
            exp = (pos <= 3) ? pos : 6 - pos;
            rd(3'd6, v); chk("R7 center count", v, exp);
            chk("R7 center level", int'(pwm_pin[0]), (exp >= 2) ? 1 : 0);
        end
        wr(3'd0, 8'h00);
    endtask

    task automatic t_join();
        int hi;
        int lo;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h01); wr(3'd3, 8'h00);
        wr(3'd4, 8'h00); wr(3'd5, 8'h80);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h42);
        for (int k = 1; k <= 127; k++) step(1'b1);
        rd(3'd6, hi); rd(3'd7, lo);
        chk("R10 wide count", hi * 256 + lo, 127);
        chk("R10 wide level low", int'(pwm_pin[1]), 0);
        chk("R10 pin0 is port", int'(pwm_pin[0]), 1);
        for (int k = 1; k <= 3; k++) step(1'b1);
        rd(3'd6, hi); rd(3'd7, lo);
        chk("R10 wide count", hi * 256 + lo, 130);
        chk("R10 wide level high", int'(pwm_pin[1]), 1);
        for (int k = 1; k <= 125; k++) step(1'b1);
        rd(3'd6, hi); rd(3'd7, lo);
        chk("R10 wide count top", hi * 256 + lo, 255);
        step(1'b1);
        rd(3'd6, hi); rd(3'd7, lo);
        chk("R10 wide wrap", hi * 256 + lo, 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_edge();
        t_buffer();
        t_disabled();
        t_limits();
        t_center();
        t_join();
        finish_up();
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule